// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a processor's program sequencer and decides which interrupt it should take next. It gathers requests from a non-maskable reset source, three external request pins that may be set to edge or level sensing, and five internal pulse requests: two serial, two host and one timer. It combines them with a per-source enable mask and presents the winner as a source number and a vector address. Vector slots are four instruction words apart.

When the sequencer acknowledges the presented request, the block saves three words on its own hardware stack: the arithmetic status, the mode status and the current mask. It also marks the source as in service. A return pulse pops the saved words back onto the restore outputs and ends the highest-priority routine in service. A control register selects nested or one-at-a-time operation. A write-only register lets software set or clear latched requests.

Top module: `irq_vector_ctl`

## Requirements
- R1: After reset the reset source (number 0, vector base 0) is presented. The mask, both restore status outputs and the stack level are all zero. Acknowledging the reset source pushes nothing.
- R2: Maskable source s (1..8) competes only when mask bit s-1 is set. The reset source is never masked.
- R3: The lowest-numbered competing source wins. The order is reset, then pins 0..2 as sources 1..3, then internal requests 0..4 as sources 4..8. The vector is 4 times the source number.
- R4: Control bit j (0..2) set to 1 makes pin j edge-sensed: a synchronized falling edge latches the request until it is acknowledged. Control bit j set to 0 makes pin j level-sensed: the request follows the active-low pin after a two-flop synchronizer and is never latched.
- R5: A one-cycle pulse on internal request k latches source 4+k until that source is acknowledged or cleared.
- R6: The force/clear word sets the latch of source s when bit s-1 is 1 and clears it when bit 7+s is 1. Neither part affects a level-sensed pin. A hardware set arriving in the same cycle as a clear leaves the latch set.
- R7: With control bit 4 at 1 (nested), a source is presented only if its number is below every source in service. With bit 4 at 0 (sequential), nothing is presented while any source is in service.
- R8: Acknowledging a maskable source pushes {arithmetic status, mode status, mask} onto a stack seven entries deep. It raises the stack level by one and clears that source's latch.
- R9: A return pulse on a non-empty stack pops the last entry. The popped mask becomes the mask, and both status words appear on the restore outputs with a one-cycle restore strobe. The lowest-numbered source in service leaves service.
- R10: An acknowledge while seven entries are stacked pushes nothing and leaves the latch and level unchanged. It gives a one-cycle overflow strobe.
- R11: An acknowledge that arrives in the same cycle as a return pulse is ignored, and only the return is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq_n | input | 3 | Active-low external request pins |
| int_req | input | 5 | Internal request pulses (serial x2, host x2, timer) |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | New mask, bit s-1 enables source s |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 5 | Bits 2..0 edge select, bit 4 nested |
| fc_we | input | 1 | Force/clear write strobe |
| fc_wdata | input | 16 | Bits 7..0 force, bits 15..8 clear |
| astat_in | input | 8 | Arithmetic status to save |
| mstat_in | input | 7 | Mode status to save |
| ack | input | 1 | Sequencer takes the presented request |
| rti | input | 1 | Return-from-interrupt pulse |
| irq_valid | output | 1 | A request is presented |
| irq_id | output | 4 | Presented source number |
| irq_vector | output | 14 | Presented vector address |
| mask_o | output | 8 | Current mask |
| astat_o | output | 8 | Restored arithmetic status |
| mstat_o | output | 7 | Restored mode status |
| restore_o | output | 1 | One-cycle strobe on a pop |
| stk_ovf_o | output | 1 | One-cycle strobe on a refused push |
| stk_level_o | output | 3 | Entries on the status stack |

## Verification
Two collisions are provoked on purpose. In the first, an internal request pulse lands in the same cycle as a software clear of that same latch, and the source must still be presented afterwards. In the second, the sequencer raises acknowledge and return together while a request is pending. The stack level must not grow, the request must stay pending, and no overflow strobe may appear. Both outcomes are judged one cycle later, at the ports.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int DEF_NUM_EXT   = 3;
    localparam int DEF_NUM_INT   = 5;
    localparam int DEF_VEC_W     = 14;
    localparam int DEF_ASTAT_W   = 8;
    localparam int DEF_MSTAT_W   = 7;
    localparam int DEF_STK_DEPTH = 7;
    localparam int DEF_NEST_BIT  = 4;
    localparam int SLOT_SHIFT    = 2;   // four words per vector slot

    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic active,
    output logic fall
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.s1   = pin_n;
        s_d.s2   = s_q.s1;
        s_d.prev = s_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1};
        else        s_q <= s_d;
    end

    assign active = ~s_q.s2;
    assign fall   = s_q.prev & ~s_q.s2;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N   = 9,
    parameter int IDW = 4
) (
    input  logic [N-1:0]   req,
    input  logic [N-1:0]   svc,
    input  logic           nested,
    output logic           valid,
    output logic [IDW-1:0] id
);
    int          lvl;
    logic        svc_any;
    logic [N-1:0] elig;

    always_comb begin
        svc_any = |svc;
        lvl     = N;
        for (int i = N - 1; i >= 0; i--) begin
            if (svc[i]) lvl = i;
        end
        for (int i = 0; i < N; i++) begin
            elig[i] = req[i] && (!svc_any || (nested && (i < lvl)));
        end
        valid = |elig;
        id    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) id = IDW'(i);
        end
    end
endmodule

// File: rtl/irq_stat_stack.sv
module irq_stat_stack
    import irq_ctl_pkg::*;
#(
    parameter int W     = 23,
    parameter int DEPTH = 7,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_op_e       op,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [PW-1:0] level,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           ptr;
    } stk_t;

    stk_t s_d, s_q;
    logic [PW-1:0] top_idx;

    assign top_idx = s_q.ptr - PW'(1);
    assign empty   = (s_q.ptr == '0);
    assign full    = (s_q.ptr == PW'(DEPTH));
    assign level   = s_q.ptr;
    assign rdata   = empty ? '0 : s_q.mem[top_idx];

    always_comb begin
        s_d = s_q;
        if (op == STK_POP && !empty) begin
            s_d.ptr = s_q.ptr - PW'(1);
        end else if (op == STK_PUSH && !full) begin
            s_d.mem[s_q.ptr] = wdata;
            s_d.ptr          = s_q.ptr + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
    import irq_ctl_pkg::*;
#(
    parameter int NUM_EXT   = DEF_NUM_EXT,
    parameter int NUM_INT   = DEF_NUM_INT,
    parameter int VEC_W     = DEF_VEC_W,
    parameter int VEC_BASE  = 0,
    parameter int ASTAT_W   = DEF_ASTAT_W,
    parameter int MSTAT_W   = DEF_MSTAT_W,
    parameter int STK_DEPTH = DEF_STK_DEPTH,
    parameter int NEST_BIT  = DEF_NEST_BIT,
    localparam int NSRC = 1 + NUM_EXT + NUM_INT,
    localparam int IDW  = $clog2(NSRC),
    localparam int MW   = NSRC - 1,
    localparam int FCW  = 2 * MW,
    localparam int CTLW = NEST_BIT + 1,
    localparam int PW   = $clog2(STK_DEPTH + 1),
    localparam int SW   = ASTAT_W + MSTAT_W + MW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_irq_n,
    input  logic [NUM_INT-1:0] int_req,
    input  logic               mask_we,
    input  logic [MW-1:0]      mask_wdata,
    input  logic               ctl_we,
    input  logic [CTLW-1:0]    ctl_wdata,
    input  logic               fc_we,
    input  logic [FCW-1:0]     fc_wdata,
    input  logic [ASTAT_W-1:0] astat_in,
    input  logic [MSTAT_W-1:0] mstat_in,
    input  logic               ack,
    input  logic               rti,
    output logic               irq_valid,
    output logic [IDW-1:0]     irq_id,
    output logic [VEC_W-1:0]   irq_vector,
    output logic [MW-1:0]      mask_o,
    output logic [ASTAT_W-1:0] astat_o,
    output logic [MSTAT_W-1:0] mstat_o,
    output logic               restore_o,
    output logic               stk_ovf_o,
    output logic [PW-1:0]      stk_level_o
);
    typedef struct packed {
        logic               rst_pend;
        logic [NSRC-1:1]    lat;
        logic [NSRC-1:0]    in_svc;
        logic [MW-1:0]      mask;
        logic [NUM_EXT-1:0] edge_sel;
        logic               nested;
        logic [ASTAT_W-1:0] astat;
        logic [MSTAT_W-1:0] mstat;
        logic               restore;
        logic               ovf;
    } ctl_state_t;

    ctl_state_t s_d, s_q;

    logic [NUM_EXT-1:0] pin_act, pin_fall;
    logic [NSRC-1:0]    pend, masked;
    logic               pick_valid;
    logic [IDW-1:0]     pick_id;
    stk_op_e            stk_op;
    logic [SW-1:0]      stk_wdata, stk_rdata;
    logic               stk_full, stk_empty;
    logic [PW-1:0]      stk_level;
    logic               take, take_rst, do_push, do_pop, ovf_hit;
    logic [NSRC-1:1]    hw_set, fc_ok, set_v, clr_v;
    logic [MW-1:0]      fc_force, fc_clear;
    logic               ctl_unused;

    // Edge detectors and synchronizers, one per pin
    for (genvar g = 0; g < NUM_EXT; g++) begin : g_pin
        irq_pin_sync u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_n  (ext_irq_n[g]),
            .active (pin_act[g]),
            .fall   (pin_fall[g])
        );
    end

    assign ctl_unused = ^ctl_wdata;
    assign fc_force   = fc_wdata[MW-1:0];
    assign fc_clear   = fc_wdata[FCW-1:MW];

    // Pending requests per source
    always_comb begin
        pend[0] = s_q.rst_pend;
        for (int i = 1; i < NSRC; i++) begin
            if (i <= NUM_EXT) begin
                pend[i]   = s_q.edge_sel[i-1] ? s_q.lat[i] : pin_act[i-1];
                hw_set[i] = pin_fall[i-1] & s_q.edge_sel[i-1];
                fc_ok[i]  = s_q.edge_sel[i-1];
            end else begin
                pend[i]   = s_q.lat[i];
                hw_set[i] = int_req[i-1-NUM_EXT];
                fc_ok[i]  = 1'b1;
            end
        end
        masked = pend & {s_q.mask, 1'b1};
    end

    irq_prio_pick #(.N(NSRC), .IDW(IDW)) u_pick (
        .req    (masked),
        .svc    (s_q.in_svc),
        .nested (s_q.nested),
        .valid  (pick_valid),
        .id     (pick_id)
    );

    // Acknowledge and return decisions
    always_comb begin
        take     = ack && pick_valid && !rti;
        take_rst = take && (pick_id == '0);
        do_push  = take && !take_rst && !stk_full;
        ovf_hit  = take && !take_rst && stk_full;
        do_pop   = rti && !stk_empty;
        if (do_pop)       stk_op = STK_POP;
        else if (do_push) stk_op = STK_PUSH;
        else              stk_op = STK_IDLE;
        stk_wdata = {astat_in, mstat_in, s_q.mask};
    end

    irq_stat_stack #(.W(SW), .DEPTH(STK_DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (stk_op),
        .wdata (stk_wdata),
        .rdata (stk_rdata),
        .level (stk_level),
        .full  (stk_full),
        .empty (stk_empty)
    );

    // Next state
    always_comb begin
        s_d         = s_q;
        s_d.restore = do_pop;
        s_d.ovf     = ovf_hit;

        for (int i = 1; i < NSRC; i++) begin
            set_v[i] = hw_set[i] | (fc_we & fc_ok[i] & fc_force[i-1]);
            clr_v[i] = (fc_we & fc_ok[i] & fc_clear[i-1]) |
                       (do_push && (pick_id == IDW'(i)));
            if (set_v[i])      s_d.lat[i] = 1'b1;
            else if (clr_v[i]) s_d.lat[i] = 1'b0;
        end

        if (take_rst) s_d.rst_pend = 1'b0;

        if (rti) begin
            for (int i = NSRC - 1; i >= 0; i--) begin
                if (s_q.in_svc[i]) s_d.in_svc = s_q.in_svc & ~(NSRC'(1) << i);
            end
        end
        if (do_push) s_d.in_svc[pick_id] = 1'b1;

        if (ctl_we) begin
            s_d.edge_sel = ctl_wdata[NUM_EXT-1:0];
            s_d.nested   = ctl_wdata[NEST_BIT];
        end

        if (mask_we) s_d.mask = mask_wdata;
        if (do_pop) begin
            s_d.mask  = stk_rdata[MW-1:0];
            s_d.mstat = stk_rdata[MW +: MSTAT_W];
            s_d.astat = stk_rdata[MW+MSTAT_W +: ASTAT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.rst_pend <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_valid   = pick_valid;
    assign irq_id      = pick_id;
    assign irq_vector  = VEC_W'(VEC_BASE) + (VEC_W'(pick_id) << SLOT_SHIFT);
    assign mask_o      = s_q.mask;
    assign astat_o     = s_q.astat;
    assign mstat_o     = s_q.mstat;
    assign restore_o   = s_q.restore;
    assign stk_ovf_o   = s_q.ovf;
    assign stk_level_o = stk_level;
endmodule

// File: rtl/irq_vector_ctl_chk.sv
module irq_vector_ctl_chk #(
    parameter int NSRC  = 9,
    parameter int IDW   = 4,
    parameter int MW    = 8,
    parameter int PW    = 3,
    parameter int DEPTH = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ack,
    input logic            rti,
    input logic            irq_valid,
    input logic [IDW-1:0]  irq_id,
    input logic [MW-1:0]   mask_o,
    input logic [PW-1:0]   stk_level_o,
    input logic            stk_ovf_o,
    input logic            restore_o,
    input logic [NSRC-1:0] svc,
    input logic            nested
);
    // R2: a presented maskable source has its enable bit set
    p_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_id != '0) |-> |(mask_o & (MW'(1) << (irq_id - IDW'(1)))));

    // R7: sequential mode presents nothing while a routine is in service
    p_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && (|svc)) |-> nested);

    // R8: an accepted acknowledge grows the stack by one
    p_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !rti && irq_valid && irq_id != '0 && stk_level_o != PW'(DEPTH))
        |=> (stk_level_o == $past(stk_level_o) + PW'(1)));

    // R9: a return on a non-empty stack pops and strobes restore
    p_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && stk_level_o != '0) |=> (restore_o && stk_level_o == $past(stk_level_o) - PW'(1)));

    // R10: acknowledge on a full stack is refused with an overflow strobe
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !rti && irq_valid && irq_id != '0 && stk_level_o == PW'(DEPTH))
        |=> (stk_ovf_o && stk_level_o == PW'(DEPTH)));

    // R11: acknowledge together with return never pushes
    p_ack_rti_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && rti) |=> (!stk_ovf_o && stk_level_o <= $past(stk_level_o)));
endmodule

bind irq_vector_ctl irq_vector_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .rti         (rti),
    .irq_valid   (irq_valid),
    .irq_id      (irq_id),
    .mask_o      (mask_o),
    .stk_level_o (stk_level_o),
    .stk_ovf_o   (stk_ovf_o),
    .restore_o   (restore_o),
    .svc         (s_q.in_svc),
    .nested      (s_q.nested)
);

// File: tb/sim_irq_vector_ctl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ext_irq_n = 3'b111;
    logic [4:0]  int_req = '0;
    logic        mask_we = 1'b0;
    logic [7:0]  mask_wdata = '0;
    logic        ctl_we = 1'b0;
    logic [4:0]  ctl_wdata = '0;
    logic        fc_we = 1'b0;
    logic [15:0] fc_wdata = '0;
    logic [7:0]  astat_in = '0;
    logic [6:0]  mstat_in = '0;
    logic        ack = 1'b0;
    logic        rti = 1'b0;
    logic        irq_valid;
    logic [3:0]  irq_id;
    logic [13:0] irq_vector;
    logic [7:0]  mask_o;
    logic [7:0]  astat_o;
    logic [6:0]  mstat_o;
    logic        restore_o;
    logic        stk_ovf_o;
    logic [2:0]  stk_level_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_vector_ctl u0 (.*);

    // {mask[7:0], force[7:0], exp_valid, exp_id[3:0]}
    localparam logic [20:0] TBL [8] = '{
        {8'hFF, 8'hFF, 1'b1, 4'd1},
        {8'hFE, 8'hFF, 1'b1, 4'd2},
        {8'h00, 8'hFF, 1'b0, 4'd0},
        {8'h80, 8'hFF, 1'b1, 4'd8},
        {8'hFF, 8'h00, 1'b0, 4'd0},
        {8'hFF, 8'h30, 1'b1, 4'd5},
        {8'h0F, 8'h30, 1'b0, 4'd0},
        {8'h24, 8'hFF, 1'b1, 4'd3}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_pick(input string tag, input bit ev, input int eid);
        chk(irq_valid == ev, tag, 32'(irq_valid), 32'(ev));
        if (ev) begin
            chk(irq_id == 4'(eid), tag, 32'(irq_id), 32'(eid));
            chk(irq_vector == 14'(eid * 4), tag, 32'(irq_vector), 32'(eid * 4));
        end
    endtask

    task automatic wr_mask(input logic [7:0] v);
        mask_we = 1'b1; mask_wdata = v; step(); mask_we = 1'b0;
    endtask

    task automatic wr_ctl(input logic [4:0] v);
        ctl_we = 1'b1; ctl_wdata = v; step(); ctl_we = 1'b0;
    endtask

    task automatic wr_fc(input logic [7:0] f, input logic [7:0] c);
        fc_we = 1'b1; fc_wdata = {c, f}; step(); fc_we = 1'b0;
    endtask

    task automatic do_ack(input logic [7:0] a, input logic [6:0] m);
        astat_in = a; mstat_in = m; ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic do_rti();
        rti = 1'b1; step(); rti = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk_pick("R1 reset presented", 1'b1, 0);
        chk(mask_o == 8'h00, "R1 mask", 32'(mask_o), 0);
        chk(astat_o == '0 && mstat_o == '0, "R1 status", 32'({astat_o, mstat_o}), 0);
        chk(stk_level_o == 3'd0, "R1 level", 32'(stk_level_o), 0);
        do_ack(8'h00, 7'h00);
        chk(irq_valid == 1'b0 && stk_level_o == 3'd0, "R1 reset ack no push",
            32'({irq_valid, stk_level_o}), 0);

        // R2 R3 table walk: edge mode on all pins, sequential
        wr_ctl(5'b00111);
        foreach (TBL[n]) begin
            wr_mask(TBL[n][20:13]);
            wr_fc(TBL[n][12:5], 8'h00);
            chk_pick($sformatf("R2 R3 row %0d", n), TBL[n][4], int'(TBL[n][3:0]));
            wr_fc(8'h00, 8'hFF);
        end
        wr_mask(8'hFF);

        // R4 edge latch on pin 0 (source 1)
        ext_irq_n[0] = 1'b0;
        repeat (3) step();
        ext_irq_n[0] = 1'b1;
        repeat (3) step();
        chk_pick("R4 edge latched", 1'b1, 1);
        // R8 push and latch clear
        do_ack(8'hA5, 7'h12);
        chk(stk_level_o == 3'd1, "R8 level after ack", 32'(stk_level_o), 1);
        chk(irq_valid == 1'b0, "R8 latch cleared", 32'(irq_valid), 0);
        wr_mask(8'h00);
        // R9 pop restores
        do_rti();
        chk(restore_o == 1'b1, "R9 restore strobe", 32'(restore_o), 1);
        chk(astat_o == 8'hA5, "R9 astat", 32'(astat_o), 32'hA5);
        chk(mstat_o == 7'h12, "R9 mstat", 32'(mstat_o), 32'h12);
        chk(mask_o == 8'hFF, "R9 mask restored", 32'(mask_o), 32'hFF);
        chk(stk_level_o == 3'd0, "R9 level", 32'(stk_level_o), 0);
        step();
        chk(restore_o == 1'b0, "R9 strobe one cycle", 32'(restore_o), 0);

        // R4 level mode on pin 0
        wr_ctl(5'b00110);
        ext_irq_n[0] = 1'b0;
        repeat (3) step();
        chk_pick("R4 level active", 1'b1, 1);
        wr_fc(8'h00, 8'h01);
        chk_pick("R6 clear ignored on level pin", 1'b1, 1);
        ext_irq_n[0] = 1'b1;
        repeat (3) step();
        chk_pick("R4 level released", 1'b0, 0);
        wr_fc(8'h01, 8'h00);
        chk_pick("R6 force ignored on level pin", 1'b0, 0);
        wr_ctl(5'b00111);

        // R5 internal request latch (source 8)
        int_req[4] = 1'b1; step(); int_req[4] = 1'b0;
        repeat (2) step();
        chk_pick("R5 internal latched", 1'b1, 8);
        wr_fc(8'h00, 8'h80);
        chk_pick("R6 software clear", 1'b0, 0);

        // R6 collision: new pulse and clear on source 4 in one cycle
        int_req[0] = 1'b1; fc_we = 1'b1; fc_wdata = {8'h08, 8'h00};
        step();
        int_req[0] = 1'b0; fc_we = 1'b0;
        chk_pick("R6 set wins over clear", 1'b1, 4);

        // R7 nesting
        wr_ctl(5'b10111);
        do_ack(8'h11, 7'h01);
        chk(stk_level_o == 3'd1, "R8 nested push", 32'(stk_level_o), 1);
        wr_fc(8'h80, 8'h00);
        chk_pick("R7 lower priority held", 1'b0, 0);
        wr_fc(8'h02, 8'h00);
        chk_pick("R7 higher priority preempts", 1'b1, 2);
        wr_ctl(5'b00111);
        chk_pick("R7 sequential blocks", 1'b0, 0);
        wr_ctl(5'b10111);
        do_ack(8'h22, 7'h02);
        chk(stk_level_o == 3'd2 && irq_valid == 1'b0, "R7 second level",
            32'({irq_valid, stk_level_o}), 2);
        do_rti();
        chk(astat_o == 8'h22, "R9 LIFO first pop", 32'(astat_o), 32'h22);
        chk_pick("R7 src 8 still below src 4", 1'b0, 0);
        do_rti();
        chk(astat_o == 8'h11, "R9 LIFO second pop", 32'(astat_o), 32'h11);
        chk_pick("R9 service ended", 1'b1, 8);

        // R11 ack with rti
        ack = 1'b1; rti = 1'b1; step(); ack = 1'b0; rti = 1'b0;
        chk(stk_level_o == 3'd0, "R11 no push", 32'(stk_level_o), 0);
        chk_pick("R11 request kept", 1'b1, 8);

        // R10 fill the stack then overflow
        do_ack(8'd8, 7'd8);
        for (int k = 7; k >= 2; k--) begin
            wr_fc(8'(1 << (k - 1)), 8'h00);
            chk_pick($sformatf("R3 nest fill %0d", k), 1'b1, k);
            do_ack(8'(k), 7'(k));
        end
        chk(stk_level_o == 3'd7, "R8 stack full", 32'(stk_level_o), 7);
        wr_fc(8'h01, 8'h00);
        do_ack(8'hEE, 7'h7F);
        chk(stk_ovf_o == 1'b1, "R10 overflow strobe", 32'(stk_ovf_o), 1);
        chk(stk_level_o == 3'd7, "R10 level held", 32'(stk_level_o), 7);
        chk_pick("R10 request not taken", 1'b1, 1);
        step();
        chk(stk_ovf_o == 1'b0, "R10 strobe one cycle", 32'(stk_ovf_o), 0);
        do_rti();
        chk(astat_o == 8'd2, "R9 pop after fill", 32'(astat_o), 2);
        for (int k = 0; k < 6; k++) do_rti();
        chk(stk_level_o == 3'd0, "R9 drained", 32'(stk_level_o), 0);
        chk(mask_o == 8'hFF, "R9 final mask", 32'(mask_o), 32'hFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule